// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave in front of a 2048 x 8 byte memory. It runs on a fast system clock and oversamples the bus clock and data lines through two-stage synchronizers. It pulls the data line low through an output-enable signal (`sda_oe_o` high means drive low). It recognises start and stop conditions and takes a device address byte. The middle three bits of that byte select the upper part of the 11-bit memory address. A word address byte then supplies the low eight bits.

Written bytes go into a 16-entry page buffer, one valid flag per entry. The buffer is committed only when a stop arrives. The commit opens an internally timed write cycle of `WR_CYCLES` system clocks. During that cycle the slave ignores the bus completely, so a master can poll for completion by repeating start plus device address. Read transfers stream bytes from the current address and advance the full 11-bit address after each byte. A write-protect input guards the whole array.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and puts the slave into device-address reception. A rising SDA while SCL is high is a stop and returns it to idle. `sda_oe_o` is 0 after reset and while idle.
- R2: A device address byte whose bits 7:4 equal 1010 is acknowledged. Any other pattern gets no acknowledge, and the slave ignores the bus until the next start.
- R3: The slave acknowledges each accepted address and write data byte by holding SDA low for the whole ninth SCL high period. Bytes are received MSB first, sampled on SCL rising.
- R4: A byte write is device byte with bit 0 = 0, then a word address, then one data byte and a stop. It stores the byte, and a later read returns it.
- R5: Within one write, successive data bytes advance only address bits 3:0. Bytes past the end of a 16-byte page wrap to its start, and later bytes overwrite earlier ones.
- R6: Device byte bits 3:1 become memory address bits 10:8, and the word address byte gives bits 7:0.
- R7: A stop after at least one accepted data byte (write protect low) starts a write cycle of `WR_CYCLES` clocks. During that cycle device address bytes are not acknowledged. After it ends they are acknowledged again.
- R8: With `wp_i` high at the stop, data bytes are still acknowledged, but memory is unchanged and no write cycle starts.
- R9: A start that arrives before the stop discards all buffered write data, so nothing is written and no write cycle starts.
- R10: A read is device byte with bit 0 = 1. It returns the byte at the current address and then increments the full 11-bit address, wrapping from 2047 to 0. A read that follows a write-mode device byte and a word address, then a repeated start, begins at that address.
- R11: Read data is shifted out MSB first. The slave changes SDA only while SCL is low. A master no-acknowledge followed by a stop ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect; high blocks commits to the array |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
Two functions can meet in the same cycle: the expiry of the internal write-cycle counter and the arrival of a start from a master that is polling for completion. Polls are issued back to back, starting right after each committing stop. One poll therefore straddles the end of the cycle. The bench requires the first poll to go unacknowledged and a later one to be acknowledged, and then reads the data back to confirm the commit finished intact. A second pairing, a repeated start landing on a non-empty page buffer, is provoked directly and judged by an immediate acknowledge and unchanged read-back data.

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 250000,  // must be at least 1 << PAGE_W
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES);
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD} state_t;

  logic [SYNC_LEN:0] scl_p, sda_p;
  logic scl_q, scl_d, sda_q, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  state_t                state;
  logic [3:0]            bitcnt;
  logic [7:0]            shreg;
  logic [ADDR_W-1:0]     addr;
  logic                  rw, mnack, busy;
  logic [CNT_W-1:0]      wcnt;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_LEN-1:0], scl_i};
      sda_p <= {sda_p[SYNC_LEN-1:0], sda_i};
    end

  assign scl_q     = scl_p[SYNC_LEN-1];
  assign scl_d     = scl_p[SYNC_LEN];
  assign sda_q     = sda_p[SYNC_LEN-1];
  assign sda_d     = sda_p[SYNC_LEN];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr     <= '0;
      rw       <= 1'b0;
      mnack    <= 1'b0;
      busy     <= 1'b0;
      wcnt     <= '0;
      vld      <= '0;
      sda_oe_o <= 1'b0;
      pbuf     <= '{default: '0};
    end else if (busy) begin
      wcnt <= wcnt + 1'b1;
      if (wcnt == CNT_W'(WR_CYCLES - 1)) begin
        busy <= 1'b0;
        vld  <= '0;
      end
    end else if (start_det) begin
      state    <= S_DEV;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
      vld      <= '0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
      if (|vld) begin
        if (wp_i) vld <= '0;
        else begin
          busy <= 1'b1;
          wcnt <= '0;
        end
      end
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != S_RD) shreg <= {shreg[6:0], sda_q};
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (state == S_RD) mnack <= sda_q;
        end
      end else if (scl_fall) begin
        if (state == S_RD && bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          shreg    <= shreg << 1;
          sda_oe_o <= ~shreg[6];
        end else if (bitcnt == 4'd8) begin
          case (state)
            S_DEV:
              if (shreg[7:4] == DEV_ID) begin
                sda_oe_o           <= 1'b1;
                addr[ADDR_W-1:8]   <= shreg[HI_W:1];
                rw                 <= shreg[0];
              end else state <= S_IDLE;
            S_WA: begin
              sda_oe_o   <= 1'b1;
              addr[7:0]  <= shreg;
            end
            S_WD: begin
              sda_oe_o                <= 1'b1;
              pbuf[addr[PAGE_W-1:0]]  <= shreg;
              vld[addr[PAGE_W-1:0]]   <= 1'b1;
              addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
            end
            S_RD: begin
              sda_oe_o <= 1'b0;
              addr     <= addr + 1'b1;
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          sda_oe_o <= 1'b0;
          case (state)
            S_DEV:
              if (rw) begin
                state    <= S_RD;
                shreg    <= mem[addr];
                sda_oe_o <= ~mem[addr][7];
              end else state <= S_WA;
            S_WA: state <= S_WD;
            S_RD:
              if (mnack) state <= S_IDLE;
              else begin
                shreg    <= mem[addr];
                sda_oe_o <= ~mem[addr][7];
              end
            default: ;
          endcase
        end
      end
    end

  always_ff @(posedge clk)
    if (busy && wcnt < CNT_W'(PAGE_BYTES) && vld[wcnt[PAGE_W-1:0]])
      mem[{addr[ADDR_W-1:PAGE_W], wcnt[PAGE_W-1:0]}] <= pbuf[wcnt[PAGE_W-1:0]];

endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe_o,
  input logic              busy,
  input logic              wp_i,
  input logic [2:0]        state,
  input logic [ADDR_W-1:0] addr
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 |-> !sda_oe_o);

  p_start_enters_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !busy |=> state == 3'd1);

  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd3 && $past(state) == 3'd3 |-> addr[ADDR_W-1:4] == $past(addr[ADDR_W-1:4]));

  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o);

  p_wp_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && wp_i && !busy |=> !busy);

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o != $past(sda_oe_o) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_q));
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_det(start_det), .stop_det(stop_det),
  .sda_oe_o(sda_oe_o), .busy(busy), .wp_i(wp_i), .state(state), .addr(addr)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WRC        = 600;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_oe;
  logic sda;
  assign sda = ~(m_low | sda_oe);

  int  errs = 0, nchk = 0;
  bit  done = 0;
  logic [7:0] ref_m [2048];
  bit         known [2048];
  logic [7:0] wdat [32];

  serial_eeprom_slave #(.WR_CYCLES(WRC)) i_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .wp_i(wp), .sda_oe_o(sda_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [7:0] dev(input [10:0] a, input bit r);
    return {4'b1010, a[10:8], r};
  endfunction

  function automatic [10:0] in_page(input [10:0] a, input int k);
    return {a[10:4], 4'(int'(a[3:0]) + k)};
  endfunction

  task automatic bstart;
    m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bstop;
    m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(2*Q);
  endtask

  task automatic send(input [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
    m_low = 0; tick(Q); scl = 1; tick(1); ack = ~sda; tick(Q);
    if (sda != ~ack) ack = 0;
    scl = 0; tick(Q);
  endtask

  task automatic recv(output [7:0] b, input bit nack, output bit glitch);
    glitch = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(2*Q); scl = 1; tick(1);
      b[i] = sda; tick(Q);
      if (sda != b[i]) glitch = 1;
      tick(Q-1); scl = 0;
    end
    tick(Q); m_low = ~nack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(1); m_low = 0;
  endtask

  task automatic write_seq(input [10:0] a, input int n, input string req);
    bit ack;
    bstart;
    send(dev(a, 0), ack); chk(ack, "R3 device byte ack", ack, 1);
    send(a[7:0], ack);    chk(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send(wdat[k], ack); chk(ack, req, ack, 1);
    end
    bstop;
    if (!wp)
      for (int k = 0; k < n; k++) begin
        ref_m[in_page(a, k)] = wdat[k];
        known[in_page(a, k)] = 1;
      end
  endtask

  task automatic poll(output int polls);
    bit ack;
    polls = 0;
    do begin
      bstart; send(dev(11'h0, 0), ack); bstop; polls++;
    end while (!ack && polls < 40);
  endtask

  task automatic read_seq(input [10:0] a, input int n, input string req);
    bit ack, g;
    logic [7:0] b;
    bstart;
    send(dev(a, 0), ack);
    send(a[7:0], ack);
    bstart;
    send(dev(a, 1), ack); chk(ack, "R10 read device ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [10:0] x;
      x = 11'(int'(a) + k);
      recv(b, k == n - 1, g);
      chk(!g, "R11 data stable while SCL high", g, 0);
      if (known[x]) chk(b === ref_m[x], req, b, ref_m[x]);
    end
    bstop;
    chk(sda_oe == 0, "R11 released after nack and stop", sda_oe, 0);
  endtask

  task automatic commit_poll(input string req);
    int p;
    poll(p);
    chk(p >= 2 && p < 40, req, p, 2);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    bit ack;
    int p;
    void'($urandom(32'h5EED));
    tick(5);
    chk(sda_oe == 0, "R1 reset release", sda_oe, 0);
    rst_n = 1; tick(5);

    // R2: wrong device pattern, then bytes after it are ignored
    bstart; send(8'hB0, ack); chk(!ack, "R2 mismatch no ack", ack, 0);
    send(8'hA0, ack); chk(!ack, "R2 ignored until start", ack, 0);
    bstop;

    // R4/R6: byte writes that differ only in device-byte address bits
    wdat[0] = 8'h3C; write_seq(11'h5A3, 1, "R4 data ack");
    commit_poll("R7 busy then ack");
    wdat[0] = 8'hC3; write_seq(11'h1A3, 1, "R4 data ack");
    commit_poll("R7 busy then ack");
    read_seq(11'h5A3, 1, "R6 upper bits 5");
    read_seq(11'h1A3, 1, "R4 byte read back");

    // R5: 20 bytes into one page wrap and overwrite
    for (int k = 0; k < 20; k++) wdat[k] = 8'(8'h40 + k);
    write_seq(11'h234, 20, "R5 page data ack");
    commit_poll("R7 page commit");
    read_seq(11'h230, 16, "R5 wrapped page");

    // R8: write protect acks but does not commit or go busy
    wp = 1; wdat[0] = 8'hEE; wdat[1] = 8'hDD;
    write_seq(11'h5A3, 2, "R8 data ack under protect");
    poll(p); chk(p == 1, "R8 no write cycle", p, 1);
    wp = 0;
    read_seq(11'h5A3, 1, "R8 array unchanged");

    // R9: repeated start discards buffered bytes
    bstart; send(dev(11'h1A3, 0), ack); send(8'hA3, ack);
    send(8'h77, ack); chk(ack, "R9 data ack", ack, 1);
    bstart; bstop;
    poll(p); chk(p == 1, "R9 no write cycle", p, 1);
    read_seq(11'h1A3, 1, "R9 data discarded");

    // R10: read crosses top of array
    for (int k = 0; k < 16; k++) wdat[k] = 8'(8'h90 + k);
    write_seq(11'h7F0, 16, "R10 setup ack");
    commit_poll("R7 commit top page");
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    write_seq(11'h000, 2, "R10 setup ack");
    commit_poll("R7 commit bottom page");
    read_seq(11'h7FE, 4, "R10 address wraps to 0");

    // constrained random writes and reads
    for (int it = 0; it < 6; it++) begin
      logic [10:0] a;
      int n;
      a  = 11'($urandom % 2048);
      n  = 1 + int'($urandom % 18);
      wp = ($urandom % 5) == 0;
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      write_seq(a, n, "R5 random data ack");
      poll(p);
      if (wp) chk(p == 1, "R8 random protect", p, 1);
      else    chk(p >= 2 && p < 40, "R7 random commit", p, 2);
      wp = 0;
      read_seq({a[10:4], 4'h0}, 16, "R5 random page contents");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule